// File: doc/BRIEF.md
# System and Return Control Unit

This block executes the operand-free system instructions of a small 8-bit controller whose instruction words are 13 bits wide. It recognises the no-op, sleep, watchdog-clear, interrupt enable and disable, subroutine return and return-from-interrupt words. It owns a circular return-address stack, a global interrupt-enable flag and the time-out (T) and power-down (P) status bits. Its outputs are strobes for the watchdog counter, the oscillator and the program counter.

A fetch stage presents one word per cycle with `instr_valid`. Calls are reported on `call_push` with the return address. An interrupt request is accepted only while interrupts are enabled. Accepting it raises `int_take`, clears the enable flag and pushes `push_addr`. Every output is registered, so the effect of a word sampled at one rising edge is visible right after that edge.

Top module: `sysret_ctl`

## Requirements
- R1: After reset `int_en`=0, `stat_t`=1, `stat_p`=1, and `handled`, `wdt_clr`, `osc_stop`, `pc_load` and `int_take` are 0.
- R2: Word 0x0000 with `instr_valid` sets `handled` for one cycle and changes no strobe, flag or status bit.
- R3: Word 0x0003 (sleep) raises `wdt_clr` and `osc_stop` for one cycle and sets `stat_t`=1 and `stat_p`=0.
- R4: Word 0x0004 (watchdog clear) raises `wdt_clr` with `osc_stop` low and sets `stat_t`=1 and `stat_p`=1.
- R5: Word 0x0010 sets `int_en` and word 0x0011 clears it. Neither word touches `stat_t` or `stat_p`.
- R6: Word 0x0012 raises `pc_load` for one cycle, with `pc_next` equal to the most recently pushed address still on the stack. That entry is then removed (last in, first out).
- R7: Word 0x0013 acts as R6 and also sets `int_en` in the same cycle that `pc_load` is raised.
- R8: The stack holds 8 entries of 10 bits. A ninth push silently overwrites the oldest entry, and pops continue round the ring.
- R9: Any other word, inside or outside the 0x0000-0x001F range, leaves `handled` low and has no effect.
- R10: With `int_en`=1, `irq_req` raises `int_take` one cycle later, clears `int_en` in that same cycle and pushes `push_addr`. This clear overrides a set from the same word. With `int_en`=0, `irq_req` is ignored.
- R11: A return and a push in the same cycle deliver the old top on `pc_next` and replace it with `push_addr`, so the depth stays the same.
- R12: With `instr_valid` low the word is ignored, although pushes and interrupts still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | `instr` holds a word to execute |
| instr | input | 13 | Instruction word |
| call_push | input | 1 | Push `push_addr` (subroutine call) |
| push_addr | input | 10 | Return address for a call or an accepted interrupt |
| irq_req | input | 1 | Interrupt request |
| handled | output | 1 | The previous word was a recognised system word |
| wdt_clr | output | 1 | Watchdog-clear strobe |
| osc_stop | output | 1 | Oscillator-stop strobe |
| pc_load | output | 1 | Program-counter load strobe |
| pc_next | output | 10 | Return address for `pc_load` |
| int_take | output | 1 | Interrupt-accept strobe |
| int_en | output | 1 | Global interrupt-enable flag |
| stat_t | output | 1 | Time-out status bit |
| stat_p | output | 1 | Power-down status bit |

## Verification
The assertions assume that `instr` is stable and known whenever `instr_valid` is high. They also assume that reset is held for at least one edge before any other input is driven. The bench meets both by driving every input on the falling edge from one task. It holds reset for several cycles, and then sweeps all 8192 instruction words with interleaved pushes, interrupt requests and idle cycles. Stack underflow and overflow are treated as legal wrap-around, so no assertion depends on a balanced call and return sequence.

// File: rtl/sysret_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, opcode values and the decoded operation type.
// Assumes the 13-bit word layout and the 10-bit program counter of the core.
package sysret_pkg;
    localparam int IW = 13;
    localparam int PCW = 10;

    localparam logic [IW-1:0] W_NOP   = 13'h0000;
    localparam logic [IW-1:0] W_SLEEP = 13'h0003;
    localparam logic [IW-1:0] W_WDTC  = 13'h0004;
    localparam logic [IW-1:0] W_ENI   = 13'h0010;
    localparam logic [IW-1:0] W_DISI  = 13'h0011;
    localparam logic [IW-1:0] W_RET   = 13'h0012;
    localparam logic [IW-1:0] W_RETI  = 13'h0013;

    typedef enum logic [2:0] {
        OP_NONE, OP_NOP, OP_SLEEP, OP_WDTC, OP_ENI, OP_DISI, OP_RET, OP_RETI
    } sys_op_e;
endpackage

// File: rtl/sysret_decode.sv
`timescale 1ns/1ps
// Module: sysret_decode
// Maps a valid instruction word to a system operation. Any word that is not
// one of the seven system words becomes OP_NONE. Purely combinational.
module sysret_decode
    import sysret_pkg::*;
(
    input  logic          valid,
    input  logic [IW-1:0] word,
    output sys_op_e       op
);
    // Purpose: compare the word against each system opcode.
    always_comb begin
        op = OP_NONE;
        if (valid) begin
            case (word)
                W_NOP:   op = OP_NOP;
                W_SLEEP: op = OP_SLEEP;
                W_WDTC:  op = OP_WDTC;
                W_ENI:   op = OP_ENI;
                W_DISI:  op = OP_DISI;
                W_RET:   op = OP_RET;
                W_RETI:  op = OP_RETI;
                default: op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sysret_stack.sv
`timescale 1ns/1ps
// Module: sysret_stack
// Circular return-address stack. The pointer names the next free slot and
// wraps on overflow and underflow without any indication. A pop together
// with a push overwrites the current top. Assumes DEPTH is a power of two.
module sysret_stack #(
    parameter int DEPTH = 8,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] top_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic [PTR_W-1:0] sp;
    logic [PTR_W-1:0] top_idx;
    logic [PTR_W-1:0] wr_idx;
    logic             wr_en;
    logic [DEPTH-1:0][AW-1:0] ent;

    // Purpose: locate the top entry and the slot a push writes.
    always_comb begin
        top_idx  = sp - ONE;
        wr_en    = push;
        wr_idx   = pop ? top_idx : sp;
        top_data = ent[top_idx];
    end

    // Purpose: move the pointer; a simultaneous push and pop leaves it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= '0;
        else if (push && !pop)
            sp <= sp + ONE;
        else if (pop && !push)
            sp <= sp - ONE;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [AW-1:0] q;
        // Purpose: store one return address when this slot is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_idx == PTR_W'(i))
                q <= push_data;
        end
        assign ent[i] = q;
    end
endmodule

// File: rtl/sysret_flags.sv
`timescale 1ns/1ps
// Module: sysret_flags
// Holds the interrupt-enable flag and the T and P status bits. An accepted
// interrupt clears the enable flag and overrides any set in the same cycle.
module sysret_flags
    import sysret_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sys_op_e op,
    input  logic    take,
    output logic    int_en,
    output logic    stat_t,
    output logic    stat_p
);
    // Purpose: update the interrupt-enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            int_en <= 1'b0;
        else if (take)
            int_en <= 1'b0;
        else if (op == OP_ENI || op == OP_RETI)
            int_en <= 1'b1;
        else if (op == OP_DISI)
            int_en <= 1'b0;
    end

    // Purpose: update the time-out and power-down bits on sleep or watchdog clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_t <= 1'b1;
            stat_p <= 1'b1;
        end else if (op == OP_SLEEP) begin
            stat_t <= 1'b1;
            stat_p <= 1'b0;
        end else if (op == OP_WDTC) begin
            stat_t <= 1'b1;
            stat_p <= 1'b1;
        end
    end
endmodule

// File: rtl/sysret_ctl.sv
`timescale 1ns/1ps
// Module: sysret_ctl (top)
// Executes the no-operand system words, keeps the return stack and the
// interrupt flag, and registers every strobe. Assumes one word per cycle,
// qualified by instr_valid, and a synchronous active-low reset.
module sysret_ctl
    import sysret_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           instr_valid,
    input  logic [IW-1:0]  instr,
    input  logic           call_push,
    input  logic [PCW-1:0] push_addr,
    input  logic           irq_req,
    output logic           handled,
    output logic           wdt_clr,
    output logic           osc_stop,
    output logic           pc_load,
    output logic [PCW-1:0] pc_next,
    output logic           int_take,
    output logic           int_en,
    output logic           stat_t,
    output logic           stat_p
);
    sys_op_e        op;
    logic           take;
    logic           is_pop;
    logic           do_push;
    logic [PCW-1:0] top_data;

    sysret_decode u_dec (.valid(instr_valid), .word(instr), .op(op));

    // Purpose: derive interrupt accept, pop and push requests.
    always_comb begin
        take    = irq_req && int_en;
        is_pop  = (op == OP_RET) || (op == OP_RETI);
        do_push = call_push || take;
    end

    sysret_stack #(.DEPTH(DEPTH), .AW(PCW)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(do_push), .pop(is_pop),
        .push_data(push_addr), .top_data(top_data)
    );

    sysret_flags u_flg (
        .clk(clk), .rst_n(rst_n), .op(op), .take(take),
        .int_en(int_en), .stat_t(stat_t), .stat_p(stat_p)
    );

    // Purpose: register the one-cycle strobes and the return address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handled  <= 1'b0;
            wdt_clr  <= 1'b0;
            osc_stop <= 1'b0;
            pc_load  <= 1'b0;
            int_take <= 1'b0;
            pc_next  <= '0;
        end else begin
            handled  <= (op != OP_NONE);
            wdt_clr  <= (op == OP_SLEEP) || (op == OP_WDTC);
            osc_stop <= (op == OP_SLEEP);
            pc_load  <= is_pop;
            int_take <= take;
            if (is_pop)
                pc_next <= top_data;
        end
    end
endmodule

// File: rtl/sysret_chk.sv
`timescale 1ns/1ps
// Module: sysret_chk
// Property checker attached to sysret_ctl. It observes the top-level ports only.
module sysret_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [12:0] instr,
    input logic        irq_req,
    input logic        handled,
    input logic        wdt_clr,
    input logic        osc_stop,
    input logic        pc_load,
    input logic        int_take,
    input logic        int_en,
    input logic        stat_t,
    input logic        stat_p
);
    p_sleep_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop |-> (wdt_clr && stat_t && !stat_p));

    p_wdtc_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr && !osc_stop) |-> (stat_t && stat_p));

    p_ret_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> ($past(instr_valid) &&
                     ($past(instr) == 13'h0012 || $past(instr) == 13'h0013)));

    p_reti_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && $past(instr) == 13'h0013 && !int_take) |-> int_en);

    p_quiet_unhandled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !handled |-> (!wdt_clr && !osc_stop && !pc_load));

    p_take_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |-> !int_en);

    p_take_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !int_en) |=> !int_take);
endmodule

bind sysret_ctl sysret_chk i_chk (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .irq_req(irq_req), .handled(handled), .wdt_clr(wdt_clr),
    .osc_stop(osc_stop), .pc_load(pc_load), .int_take(int_take),
    .int_en(int_en), .stat_t(stat_t), .stat_p(stat_p)
);

// File: tb/test_sysret_ctl.sv
`timescale 1ns/1ps
module test_sysret_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [12:0] instr = '0;
    logic        call_push = 1'b0;
    logic [9:0]  push_addr = '0;
    logic        irq_req = 1'b0;
    logic        handled, wdt_clr, osc_stop, pc_load, int_take, int_en, stat_t, stat_p;
    logic [9:0]  pc_next;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state, kept from the requirements
    logic [9:0] m_stk [8];
    int  m_sp = 0;
    bit  m_ie = 0, m_t = 1, m_p = 1;
    string tag_force = "";

    always #2.5 clk = ~clk;

    sysret_ctl i_sysret_ctl (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .call_push(call_push), .push_addr(push_addr), .irq_req(irq_req),
        .handled(handled), .wdt_clr(wdt_clr), .osc_stop(osc_stop),
        .pc_load(pc_load), .pc_next(pc_next), .int_take(int_take),
        .int_en(int_en), .stat_t(stat_t), .stat_p(stat_p)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, predict, sample after the rising edge
    task automatic cyc(input bit v, input logic [12:0] w, input bit psh,
                       input logic [9:0] a, input bit irq);
        bit rec, take, pop;
        bit e_wdt, e_osc;
        logic [9:0] e_pc;
        string tag;
        int ti;
        @(negedge clk);
        instr_valid = v; instr = w; call_push = psh; push_addr = a; irq_req = irq;
        rec = v && (w == 13'h0 || w == 13'h3 || w == 13'h4 || (w >= 13'h10 && w <= 13'h13));
        take = irq && m_ie;
        pop = rec && (w == 13'h12 || w == 13'h13);
        e_wdt = rec && (w == 13'h3 || w == 13'h4);
        e_osc = rec && (w == 13'h3);
        e_pc = '0;
        ti = (m_sp + 7) % 8;
        if (pop) begin
            e_pc = m_stk[ti];
            if (psh || take) m_stk[ti] = a;
            else m_sp = ti;
        end else if (psh || take) begin
            m_stk[m_sp] = a;
            m_sp = (m_sp + 1) % 8;
        end
        if (take) m_ie = 0;
        else if (rec && (w == 13'h10 || w == 13'h13)) m_ie = 1;
        else if (rec && w == 13'h11) m_ie = 0;
        if (rec && w == 13'h3) begin m_t = 1; m_p = 0; end
        if (rec && w == 13'h4) begin m_t = 1; m_p = 1; end
        if (tag_force != "") tag = tag_force;
        else if (pop && (psh || take)) tag = "R11";
        else if (take || irq) tag = "R10";
        else if (!v) tag = "R12";
        else if (!rec) tag = "R9";
        else if (w == 13'h0) tag = "R2";
        else if (w == 13'h3) tag = "R3";
        else if (w == 13'h4) tag = "R4";
        else if (w == 13'h12) tag = "R6";
        else if (w == 13'h13) tag = "R7";
        else tag = "R5";
        @(posedge clk);
        #1;
        chk(tag, "handled", handled, rec);
        chk(tag, "wdt_clr", wdt_clr, e_wdt);
        chk(tag, "osc_stop", osc_stop, e_osc);
        chk(tag, "pc_load", pc_load, pop);
        if (pop) chk(tag, "pc_next", pc_next, e_pc);
        chk(tag, "int_take", int_take, take);
        chk(tag, "int_en", int_en, m_ie);
        chk(tag, "stat_t", stat_t, m_t);
        chk(tag, "stat_p", stat_p, m_p);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "int_en", int_en, 0);
        chk("R1", "stat_t", stat_t, 1);
        chk("R1", "stat_p", stat_p, 1);
        chk("R1", "strobes", {handled, wdt_clr, osc_stop, pc_load, int_take}, 0);

        cyc(1, 13'h0000, 0, 0, 0);          // R2
        cyc(1, 13'h0003, 0, 0, 0);          // R3 sleep
        cyc(1, 13'h0000, 0, 0, 0);          // R2 keeps status
        cyc(1, 13'h0004, 0, 0, 0);          // R4
        cyc(1, 13'h0010, 0, 0, 0);          // R5 set
        cyc(1, 13'h0011, 0, 0, 0);          // R5 clear
        cyc(1, 13'h0001, 0, 0, 0);          // R9
        cyc(1, 13'h001F, 0, 0, 0);          // R9
        cyc(0, 13'h0003, 0, 0, 0);          // R12 invalid word ignored
        // R6 LIFO order
        cyc(0, 0, 1, 10'h123, 0);
        cyc(0, 0, 1, 10'h2AB, 0);
        cyc(1, 13'h0012, 0, 0, 0);
        cyc(1, 13'h0012, 0, 0, 0);
        // R7 return with enable
        cyc(0, 0, 1, 10'h055, 0);
        cyc(1, 13'h0013, 0, 0, 0);
        // R10 accept, then ignored while disabled
        cyc(0, 0, 0, 10'h3C1, 1);
        cyc(0, 0, 0, 10'h3C2, 1);
        cyc(1, 13'h0012, 0, 0, 0);
        cyc(1, 13'h0010, 0, 0, 1);          // R10 irq ignored, flag set
        cyc(1, 13'h0010, 0, 10'h111, 1);    // R10 take overrides set
        // R11 pop and push together
        cyc(0, 0, 1, 10'h0AA, 0);
        cyc(1, 13'h0012, 1, 10'h0BB, 0);
        cyc(1, 13'h0012, 0, 0, 0);
        // R8 overflow: nine pushes, nine pops
        tag_force = "R8";
        for (int k = 0; k < 9; k++) cyc(0, 0, 1, 10'(16 * k + 5), 0);
        for (int k = 0; k < 9; k++) cyc(1, 13'h0012, 0, 0, 0);
        tag_force = "";
        // Full sweep of the word space with mixed pushes and requests
        for (int w = 0; w < 8192; w++) begin
            cyc(w % 11 != 0, 13'(w), w % 5 == 0, 10'($urandom), w % 7 == 0);
            if (w % 64 == 0) cyc(1, 13'h0010, 0, 0, 0);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule